// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a 32-bit virtual address to a physical address after a translation miss by searching a hashed page table held in memory. On a start pulse it latches the request: the address, whether it is an instruction fetch, whether it is a write, and whether the requester is in user mode. It uses the top four address bits to pick one of sixteen internal segment registers. It then derives the address of a primary page-table group from that segment's virtual segment ID, the page index and the table base input.

Each group holds eight 8-byte entries. The walker reads the high word of each entry in turn, one 32-bit word per request. It compares each high word with a compare word built from the segment ID and the abbreviated page index. On the first equal high word it fetches that entry's low word. If no entry in the primary group matches, the whole search runs once more on a secondary group. That group comes from the complemented hash, and the compare word then also carries the hash-ID bit.

A protection stage then turns the matched low word, the segment's key and no-execute bits and the request attributes into a permission code and a physical address. The result appears with a one-cycle `done` pulse. Both group addresses and the compare word stay visible on output registers for a fault handler.

Top module: `hpt_walker`

## Requirements
- R1: The segment register is picked by vaddr[31:28], and VSID is that register's bits [23:0]. The primary hash is VSID[18:0] XOR vaddr[27:12]. The primary group address is {base[31:25], base[24:16] OR (hash[18:10] AND base[8:0]), hash[9:0], 6'b0}, where base is `table_base`. It is shown on `hash1_reg` at the end of every walk.
- R2: The secondary hash is the primary hash XOR 0x7FFFF, and its group address is formed the same way and shown on `hash2_reg`. The secondary group is searched only when no primary entry matches.
- R3: The compare word is {1'b1 (bit 31), VSID (bits 30:7), hash-ID (bit 6), vaddr[27:22] (bits 5:0)}. The hash-ID bit is 0 on the primary pass and 1 on the secondary pass.
- R4: High words are requested in entry order at group+8*i, i = 0..7, one request at a time. On the first equal high word, the low word is requested at group+8*i+4 and no further entry is read.
- R5: When both groups miss after 16 high-word reads, `found` is 0, `perm` is 0 (none) and `paddr` is 0.
- R6: For an instruction fetch, a match still gives `found`=1 with `perm`=0 when the segment's no-execute bit (segment bit 28) is set or the entry's guarded bit (low-word bit 3) is set.
- R7: The key is 1 when user mode is on and segment bit 29 (user key) is set, or when user mode is off and segment bit 30 (supervisor key) is set. Otherwise the key is 0.
- R8: When the key is 1, with PP = low-word bits [1:0], PP 0 gives none (0). PP 2 gives read-write (2). PP 1 and PP 3 give read-only (1) on a read and none on a write.
- R9: When the key is 0, PP 3 gives read-only on a read and none on a write. Every other PP value gives read-write.
- R10: On a match, `paddr` = {low word[31:12], vaddr[11:0]}.
- R11: The primary compare word is written to `icmp_reg` for an instruction fetch or to `dcmp_reg` for a data access. The other register keeps its value.
- R12: After reset the walker is idle with `busy`, `done` and `mem_req` at 0. `mem_req` is never raised while a response is outstanding or while idle. `start` is ignored while busy, and `done` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (sampled while idle) |
| req_vaddr | input | 32 | Virtual address to translate |
| req_instr | input | 1 | 1 = instruction fetch |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| seg_we | input | 1 | Segment register write enable |
| seg_idx | input | 4 | Segment register index to write |
| seg_wdata | input | 32 | Segment register value |
| table_base | input | 32 | Page table origin (bits 31:16) and size mask (bits 8:0) |
| mem_req | output | 1 | Read request, one word |
| mem_addr | output | 32 | Byte address of the word requested |
| mem_rdata | input | 32 | Returned word |
| mem_valid | input | 1 | Response strobe for the outstanding request |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| found | output | 1 | A matching entry was found |
| perm | output | 2 | 0 none, 1 read-only, 2 read-write |
| paddr | output | 32 | Translated physical address |
| hash1_reg | output | 32 | Latched primary group address |
| hash2_reg | output | 32 | Latched secondary group address |
| icmp_reg | output | 32 | Compare word of the last instruction walk |
| dcmp_reg | output | 32 | Compare word of the last data walk |

## Verification
The bench builds the walker with its defaults: eight entries per group and sixteen segment registers. With eight entries, a full 16-probe double miss and a hit on the last slot of the secondary group fit in a short run. Its memory responder rotates the response latency through one to three cycles, so new requests follow responses both immediately and after gaps. Two table base values are used: one with an empty size mask and one with a full mask. Together they exercise both the plain origin bits and the hash-merged bits of the group address.

// File: rtl/hptw_pkg.sv
package hptw_pkg;

    localparam int SEG_NX_BIT   = 28;
    localparam int SEG_KU_BIT   = 29;
    localparam int SEG_KS_BIT   = 30;
    localparam int LO_G_BIT     = 3;
    localparam int CW_HID_BIT   = 6;
    localparam int ENTRY_BYTES  = 8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_HASH1, ST_RDHI, ST_RDLO, ST_HASH2, ST_CHECK, ST_DONE
    } walk_st_e;

    typedef enum logic [1:0] {
        PERM_NONE = 2'd0,
        PERM_RO   = 2'd1,
        PERM_RW   = 2'd2
    } perm_e;

    typedef struct packed {
        logic [23:0] vsid;
        logic        nx;
        logic        ku;
        logic        ks;
    } seg_fields_t;

    typedef struct packed {
        logic [19:0] rpn;
        logic        g;
        logic [1:0]  pp;
    } lo_fields_t;

    typedef struct packed {
        logic [27:0] off;
        logic        instr;
        logic        write;
        logic        user;
    } walk_req_t;

    function automatic seg_fields_t seg_unpack(input logic [31:0] w);
        seg_fields_t s;
        s.vsid = w[23:0];
        s.nx   = w[SEG_NX_BIT];
        s.ku   = w[SEG_KU_BIT];
        s.ks   = w[SEG_KS_BIT];
        return s;
    endfunction

    function automatic lo_fields_t lo_unpack(input logic [31:0] w);
        lo_fields_t l;
        l.rpn = w[31:12];
        l.g   = w[LO_G_BIT];
        l.pp  = w[1:0];
        return l;
    endfunction

    function automatic logic [31:0] compare_word(input logic [23:0] vsid,
                                                 input logic [5:0]  api,
                                                 input logic        hid);
        return {1'b1, vsid, hid, api};
    endfunction

    function automatic logic [31:0] group_addr(input logic [31:0] base,
                                               input logic [18:0] h);
        logic [8:0] mid;
        mid = base[24:16] | (h[18:10] & base[8:0]);
        return {base[31:25], mid, h[9:0], 6'b0};
    endfunction

endpackage

// File: rtl/hptw_hash.sv
module hptw_hash
    import hptw_pkg::*;
(
    input  logic [18:0] vsid_lo,
    input  logic [15:0] page_idx,
    input  logic [31:0] tbl_base,
    output logic [31:0] grp_pri,
    output logic [31:0] grp_sec
);
    logic [18:0] h_pri;
    logic [18:0] h_sec;

    always_comb begin
        h_pri   = vsid_lo ^ {3'b000, page_idx};
        h_sec   = h_pri ^ 19'h7FFFF;
        grp_pri = group_addr(tbl_base, h_pri);
        grp_sec = group_addr(tbl_base, h_sec);
    end
endmodule

// File: rtl/hptw_prot.sv
module hptw_prot
    import hptw_pkg::*;
(
    input  seg_fields_t seg,
    input  lo_fields_t  pte_lo,
    input  logic        is_instr,
    input  logic        is_write,
    input  logic        is_user,
    input  logic [11:0] pg_off,
    output perm_e       perm,
    output logic [31:0] paddr
);
    logic key;
    perm_e ro_or_none;

    always_comb begin
        key        = (seg.ku & is_user) | (seg.ks & ~is_user);
        ro_or_none = is_write ? PERM_NONE : PERM_RO;
        if (is_instr && (seg.nx || pte_lo.g)) begin
            perm = PERM_NONE;
        end else if (key) begin
            case (pte_lo.pp)
                2'd0:    perm = PERM_NONE;
                2'd2:    perm = PERM_RW;
                default: perm = ro_or_none;
            endcase
        end else begin
            perm = (pte_lo.pp == 2'd3) ? ro_or_none : PERM_RW;
        end
    end

    assign paddr = {pte_lo.rpn, pg_off};
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hptw_pkg::*;
#(
    parameter int GRP_ENTRIES = 8,
    parameter int SEG_COUNT   = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] req_vaddr,
    input  logic        req_instr,
    input  logic        req_write,
    input  logic        req_user,
    input  logic        seg_we,
    input  logic [3:0]  seg_idx,
    input  logic [31:0] seg_wdata,
    input  logic [31:0] table_base,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic [31:0] mem_rdata,
    input  logic        mem_valid,
    output logic        busy,
    output logic        done,
    output logic        found,
    output logic [1:0]  perm,
    output logic [31:0] paddr,
    output logic [31:0] hash1_reg,
    output logic [31:0] hash2_reg,
    output logic [31:0] icmp_reg,
    output logic [31:0] dcmp_reg
);
    localparam int IDX_W = $clog2(GRP_ENTRIES);
    localparam int SEG_W = $clog2(SEG_COUNT);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GRP_ENTRIES - 1);

    walk_st_e    st;
    walk_req_t   cur_q;
    seg_fields_t seg_rf [SEG_COUNT];
    seg_fields_t seg_q;
    lo_fields_t  lo_q;
    logic [31:0] grp_q, cmp_q;
    logic [IDX_W-1:0] idx_q;
    logic        pass2_q, pend_q, hit_q;
    logic        rsp;
    logic [31:0] grp_pri, grp_sec, cw_pri, paddr_w;
    perm_e       perm_w;

    // segment register file
    always_ff @(posedge clk) begin
        for (int s = 0; s < SEG_COUNT; s++) begin
            if (rst)
                seg_rf[s] <= '0;
            else if (seg_we && seg_idx == SEG_W'(s))
                seg_rf[s] <= seg_unpack(seg_wdata);
        end
    end

    hptw_hash u_hash (
        .vsid_lo  (seg_q.vsid[18:0]),
        .page_idx (cur_q.off[27:12]),
        .tbl_base (table_base),
        .grp_pri  (grp_pri),
        .grp_sec  (grp_sec)
    );

    hptw_prot u_prot (
        .seg      (seg_q),
        .pte_lo   (lo_q),
        .is_instr (cur_q.instr),
        .is_write (cur_q.write),
        .is_user  (cur_q.user),
        .pg_off   (cur_q.off[11:0]),
        .perm     (perm_w),
        .paddr    (paddr_w)
    );

    always_comb begin
        cw_pri   = compare_word(seg_q.vsid, cur_q.off[27:22], 1'b0);
        mem_req  = (st == ST_RDHI || st == ST_RDLO) && !pend_q;
        mem_addr = grp_q + ({{(32-IDX_W){1'b0}}, idx_q} * ENTRY_BYTES)
                 + ((st == ST_RDLO) ? 32'd4 : 32'd0);
        rsp      = pend_q && mem_valid;
        busy     = (st != ST_IDLE);
        done     = (st == ST_DONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
            cur_q <= '0;  seg_q <= '0;  lo_q <= '0;
            grp_q <= '0;  cmp_q <= '0;  idx_q <= '0;
            pass2_q <= 1'b0;  pend_q <= 1'b0;  hit_q <= 1'b0;
            found <= 1'b0;  perm <= '0;  paddr <= '0;
            hash1_reg <= '0;  hash2_reg <= '0;
            icmp_reg <= '0;  dcmp_reg <= '0;
        end else begin
            if (mem_req)
                pend_q <= 1'b1;
            else if (mem_valid)
                pend_q <= 1'b0;

            case (st)
                ST_IDLE: if (start) begin
                    cur_q <= '{off: req_vaddr[27:0], instr: req_instr,
                               write: req_write, user: req_user};
                    seg_q <= seg_rf[req_vaddr[31 -: SEG_W]];
                    st    <= ST_HASH1;
                end
                ST_HASH1: begin
                    hash1_reg <= grp_pri;
                    hash2_reg <= grp_sec;
                    cmp_q     <= cw_pri;
                    if (cur_q.instr) icmp_reg <= cw_pri;
                    else             dcmp_reg <= cw_pri;
                    grp_q   <= grp_pri;
                    idx_q   <= '0;
                    pass2_q <= 1'b0;
                    hit_q   <= 1'b0;
                    st      <= ST_RDHI;
                end
                ST_RDHI: if (rsp) begin
                    if (mem_rdata == cmp_q)
                        st <= ST_RDLO;
                    else if (idx_q == LAST_IDX)
                        st <= pass2_q ? ST_CHECK : ST_HASH2;
                    else
                        idx_q <= idx_q + 1'b1;
                end
                ST_RDLO: if (rsp) begin
                    lo_q  <= lo_unpack(mem_rdata);
                    hit_q <= 1'b1;
                    st    <= ST_CHECK;
                end
                ST_HASH2: begin
                    grp_q   <= hash2_reg;
                    cmp_q   <= cmp_q | (32'd1 << CW_HID_BIT);
                    idx_q   <= '0;
                    pass2_q <= 1'b1;
                    st      <= ST_RDHI;
                end
                ST_CHECK: begin
                    found <= hit_q;
                    perm  <= hit_q ? perm_w : PERM_NONE;
                    paddr <= hit_q ? paddr_w : 32'd0;
                    st    <= ST_DONE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hptw_chk.sv
module hptw_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       req_write,
    input logic       busy,
    input logic       done,
    input logic       found,
    input logic [1:0] perm,
    input logic       mem_req,
    input logic       mem_valid
);
    logic [1:0] outstanding;
    logic       wr_lat;

    always_ff @(posedge clk) begin
        if (rst) begin
            outstanding <= '0;
            wr_lat      <= 1'b0;
        end else begin
            if (mem_req && !mem_valid)
                outstanding <= outstanding + 2'd1;
            else if (mem_valid && !mem_req && outstanding != 2'd0)
                outstanding <= outstanding - 2'd1;
            if (start && !busy)
                wr_lat <= req_write;
        end
    end

    p_single_req_r12: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> outstanding == 2'd0);
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_busy_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);
    p_miss_noperm_r5: assert property (@(posedge clk) disable iff (rst)
        (done && !found) |-> perm == 2'd0);
    p_perm_code_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> perm != 2'd3);
    p_write_not_ro_r9: assert property (@(posedge clk) disable iff (rst)
        (done && wr_lat) |-> perm != 2'd1);
endmodule

bind hpt_walker hptw_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .req_write (req_write),
    .busy      (busy),
    .done      (done),
    .found     (found),
    .perm      (perm),
    .mem_req   (mem_req),
    .mem_valid (mem_valid)
);

// File: tb/sim_hpt_walker.sv
module sim_hpt_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_instr = 1'b0, req_write = 1'b0, req_user = 1'b0;
    logic        seg_we = 1'b0;
    logic [3:0]  seg_idx = '0;
    logic [31:0] seg_wdata = '0;
    logic [31:0] table_base = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        mem_valid = 1'b0;
    logic        busy, done, found;
    logic [1:0]  perm;
    logic [31:0] paddr, hash1_reg, hash2_reg, icmp_reg, dcmp_reg;

    always #10 clk = ~clk;

    hpt_walker u0 (
        .clk(clk), .rst(rst), .start(start), .req_vaddr(req_vaddr),
        .req_instr(req_instr), .req_write(req_write), .req_user(req_user),
        .seg_we(seg_we), .seg_idx(seg_idx), .seg_wdata(seg_wdata),
        .table_base(table_base), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_valid(mem_valid), .busy(busy),
        .done(done), .found(found), .perm(perm), .paddr(paddr),
        .hash1_reg(hash1_reg), .hash2_reg(hash2_reg),
        .icmp_reg(icmp_reg), .dcmp_reg(dcmp_reg)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] mem [logic [31:0]];
    logic [31:0] sb [16];
    logic [31:0] exp_q [$];
    logic [31:0] e_icmp = '0, e_dcmp = '0;
    int          nreq = 0;
    int          cnt = 0;
    logic [31:0] rd_addr = '0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic logic [31:0] vsid_of(input logic [31:0] va);
        return sb[va[31:28]] & 32'h00FF_FFFF;
    endfunction

    function automatic logic [31:0] grp_of(input logic [31:0] va, input int pass);
        logic [31:0] h, mid;
        h = (vsid_of(va) & 32'h7FFFF) ^ ((va >> 12) & 32'hFFFF);
        if (pass != 0) h = h ^ 32'h7FFFF;
        mid = ((table_base >> 16) & 32'h1FF) | ((h >> 10) & (table_base & 32'h1FF));
        return (table_base & 32'hFE00_0000) | (mid << 16) | ((h & 32'h3FF) << 6);
    endfunction

    function automatic logic [31:0] cw_of(input logic [31:0] va, input int pass);
        return 32'h8000_0000 | ((va >> 22) & 32'h3F) | (vsid_of(va) << 7)
             | ((pass != 0) ? 32'h40 : 32'h0);
    endfunction

    task automatic put(input logic [31:0] va, input int pass, input int slot,
                       input logic [31:0] hi, input logic [31:0] lo);
        logic [31:0] g;
        g = grp_of(va, pass) + 32'(8 * slot);
        mem[g] = hi;
        mem[g + 4] = lo;
    endtask

    task automatic wseg(input int i, input logic [31:0] d);
        @(negedge clk);
        seg_we = 1'b1; seg_idx = 4'(i); seg_wdata = d;
        sb[i] = d;
        @(negedge clk);
        seg_we = 1'b0;
    endtask

    // memory responder: one word per request, latency rotating 1..3 cycles
    always @(negedge clk) begin
        if (rst) begin
            mem_valid = 1'b0;
            cnt = 0;
        end else begin
            if (mem_valid) mem_valid = 1'b0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    mem_valid = 1'b1;
                    mem_rdata = rd(rd_addr);
                end
            end
            if (mem_req) begin
                if (exp_q.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL R4 unexpected request actual=%h expected=none", mem_addr);
                end else begin
                    check("R4 request address order", mem_addr, exp_q.pop_front());
                end
                rd_addr = mem_addr;
                nreq++;
                cnt = 1 + (nreq % 3);
            end
        end
    end

    task automatic walk(input string tag, input logic [31:0] va, input bit ins,
                        input bit wr, input bit usr, input bit e_found,
                        input logic [1:0] e_perm, input bit poke);
        logic [31:0] a, lo, e_pa;
        bit hit;
        int k;
        exp_q.delete();
        hit = 0; lo = '0;
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 8; i++) begin
                if (!hit) begin
                    a = grp_of(va, p) + 32'(8 * i);
                    exp_q.push_back(a);
                    if (rd(a) == cw_of(va, p)) begin
                        exp_q.push_back(a + 4);
                        lo = rd(a + 4);
                        hit = 1;
                    end
                end
            end
        end
        e_pa = e_found ? ((lo & 32'hFFFF_F000) | (va & 32'hFFF)) : 32'h0;
        if (ins) e_icmp = cw_of(va, 0);
        else     e_dcmp = cw_of(va, 0);
        @(negedge clk);
        start = 1'b1; req_vaddr = va; req_instr = ins; req_write = wr; req_user = usr;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        while (!done && k < 3000) begin
            @(negedge clk);
            k++;
            if (poke && k == 3) begin start = 1'b1; req_vaddr = ~va; end
            if (poke && k == 4) begin start = 1'b0; req_vaddr = va; end
        end
        if (k >= 3000) begin
            n_chk++; n_fail++;
            $display("FAIL %s walk timeout actual=busy expected=done", tag);
        end else begin
            check({tag, " found"}, 32'(found), 32'(e_found));
            check({tag, " perm"}, 32'(perm), 32'(e_perm));
            check({tag, " R10 paddr"}, paddr, e_pa);
            check({tag, " R1 hash1_reg"}, hash1_reg, grp_of(va, 0));
            check({tag, " R2 hash2_reg"}, hash2_reg, grp_of(va, 1));
            check({tag, " R11 icmp_reg"}, icmp_reg, e_icmp);
            check({tag, " R11 dcmp_reg"}, dcmp_reg, e_dcmp);
            check({tag, " R4 reads left"}, 32'(exp_q.size()), 32'd0);
        end
        @(negedge clk);
        check({tag, " R12 done one cycle"}, 32'(done), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_up();
    end

    initial begin
        logic [31:0] va;
        for (int i = 0; i < 16; i++) sb[i] = '0;
        table_base = 32'h0030_0000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R12 reset busy", 32'(busy), 32'd0);
        check("R12 reset done", 32'(done), 32'd0);
        check("R12 reset mem_req", 32'(mem_req), 32'd0);
        check("R12 reset found", 32'(found), 32'd0);

        // R1 R3 R4 R9 R10: decoy, first of two matches wins, key 0 PP 2
        wseg(1, 32'h0001_2345);
        va = 32'h1234_5678;
        mem.delete();
        put(va, 0, 0, cw_of(va, 0) ^ 32'h1, 32'hDEAD_0002);
        put(va, 0, 3, cw_of(va, 0), 32'hABCD_E002);
        put(va, 0, 5, cw_of(va, 0), 32'h1111_1003);
        walk("R4 R9 first match", va, 0, 1, 0, 1, 2'd2, 0);
        walk("R12 start ignored while busy", va, 0, 1, 0, 1, 2'd2, 1);

        // R8: supervisor key set, supervisor mode
        wseg(2, 32'h4000_0ABC);
        va = 32'h2000_3000;
        mem.delete();
        put(va, 0, 0, cw_of(va, 0), 32'h5555_5001);
        walk("R8 key1 PP1 read", va, 0, 0, 0, 1, 2'd1, 0);
        walk("R8 key1 PP1 write", va, 0, 1, 0, 1, 2'd0, 0);
        // R7: user mode ignores supervisor key
        walk("R7 user mode key0 PP1 write", va, 0, 1, 1, 1, 2'd2, 0);
        put(va, 0, 0, cw_of(va, 0), 32'h5555_5000);
        walk("R8 key1 PP0 read", va, 0, 0, 0, 1, 2'd0, 0);
        put(va, 0, 0, cw_of(va, 0), 32'h5555_5003);
        walk("R8 key1 PP3 write", va, 0, 1, 0, 1, 2'd0, 0);
        walk("R8 key1 PP3 read", va, 0, 0, 0, 1, 2'd1, 0);
        put(va, 0, 0, cw_of(va, 0), 32'h5555_5002);
        walk("R8 key1 PP2 write", va, 0, 1, 0, 1, 2'd2, 0);

        // R7: user key only
        wseg(3, 32'h2000_0777);
        va = 32'h3000_1ABC;
        mem.delete();
        put(va, 0, 1, cw_of(va, 0), 32'h0000_7001);
        walk("R7 user key user mode write", va, 0, 1, 1, 1, 2'd0, 0);
        walk("R7 user key supervisor write", va, 0, 1, 0, 1, 2'd2, 0);

        // R9: key 0
        put(va, 0, 1, cw_of(va, 0), 32'h0000_7003);
        walk("R9 key0 PP3 read", va, 0, 0, 0, 1, 2'd1, 0);
        walk("R9 key0 PP3 write", va, 0, 1, 0, 1, 2'd0, 0);
        put(va, 0, 1, cw_of(va, 0), 32'h0000_7000);
        walk("R9 key0 PP0 write", va, 0, 1, 0, 1, 2'd2, 0);

        // R2 R3: primary holds a secondary-tagged entry, secondary hits last slot
        wseg(4, 32'h0000_4321);
        va = 32'h4ABC_D123;
        mem.delete();
        put(va, 0, 2, cw_of(va, 1), 32'h8888_8002);
        put(va, 1, 7, cw_of(va, 1), 32'h9999_9002);
        walk("R2 R3 secondary hit", va, 0, 0, 0, 1, 2'd2, 0);

        // R5: nothing anywhere
        mem.delete();
        walk("R5 double miss", 32'h4000_0000, 0, 0, 0, 0, 2'd0, 0);

        // R6: no-execute segment and guarded entry
        wseg(5, 32'h1000_0055);
        va = 32'h5000_0444;
        mem.delete();
        put(va, 0, 4, cw_of(va, 0), 32'h6666_6002);
        walk("R6 no-execute fetch", va, 1, 0, 0, 1, 2'd0, 0);
        walk("R6 no-execute data read", va, 0, 0, 0, 1, 2'd2, 0);
        wseg(6, 32'h0000_0066);
        va = 32'h6000_0888;
        mem.delete();
        put(va, 0, 6, cw_of(va, 0), 32'h7777_700A);
        walk("R6 guarded fetch", va, 1, 0, 0, 1, 2'd0, 0);
        put(va, 0, 6, cw_of(va, 0), 32'h7777_7002);
        walk("R6 unguarded fetch", va, 1, 0, 0, 1, 2'd2, 0);

        // R1: full size mask merges hash bits into the origin
        table_base = 32'h00A0_01FF;
        wseg(7, 32'h00FF_FFFF);
        va = 32'h7FFF_F000;
        mem.delete();
        put(va, 1, 0, cw_of(va, 1), 32'h1234_5002);
        walk("R1 size mask group address", va, 0, 0, 0, 1, 2'd2, 0);

        repeat (5) @(negedge clk);
        finish_up();
    end
endmodule